// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between an on-chip bus master and a PCIe transaction generator. It takes a 64-bit outbound address and looks it up in a set of programmable windows. Each window holds a 64-bit match value, a 64-bit remap value, a 64-bit mask and a 32-bit action word. The action word sets the transaction kind and the optional ordering and traffic-class attributes. When a window hits, the masked part of the address is replaced by the remap value and the window's action word is decoded onto the response.

When no window hits and default mapping is on, the address passes through unchanged and a separate default action word applies. When no window hits and default mapping is off, a decode error is flagged. A request marked bypass skips the lookup and carries its own action word. Windows are programmed one 32-bit field at a time through a simple write port. Every request gets its response exactly one clock later.

Top module: `obw_xlate`

## Requirements
- R1: After reset every window is disabled, every window register and the default action word are zero (memory kind), and `rsp_valid` is low.
- R2: A window hits when bit 0 of its match low word is set and (address AND mask) equals (match AND mask). A window whose bit 0 is clear never hits.
- R3: On a hit, the translated address is (remap AND mask) OR (address AND NOT mask). Remap bits outside the mask have no effect.
- R4: Bits 15:0 of every stored mask are forced to zero whatever value is written, so address bits 15:0 always pass through unchanged and the smallest window is 64 KiB.
- R5: When several windows hit, the lowest-numbered one supplies the address, the action and `rsp_win`.
- R6: The action word is decoded as follows. Bits 3:0 form `rsp_kind` (0x0 memory, 0x4 I/O, 0x8 config type 0, 0x9 config type 1, 0xC message). Bit 11 is `rsp_attr_on`. Bits 10:8 are the traffic class, and bits 7,6,5,4 are relaxed ordering, no-snoop, poison and ID-based ordering, which appear on `rsp_flags[3:0]` in that order. The class and flags are driven as zero when bit 11 is clear.
- R7: On a miss with `map_en` high, the address is unchanged, the default action word is decoded and `rsp_default` is set.
- R8: On a miss with `map_en` low, `rsp_err` is set, the address is unchanged, and kind, class and flags are zero.
- R9: A request with `req_bypass` high is not looked up. The address is unchanged, `req_action` is decoded in place of a window action, and `rsp_hit`, `rsp_default` and `rsp_err` are all low.
- R10: `rsp_valid` equals `req_valid` of the previous cycle, and the response fields belong to the request of that cycle.
- R11: A write with `wr_en` high stores `wr_data` at the clock edge into the field chosen by `wr_sel` of window `wr_win`. The `wr_sel` codes are 0 match low, 1 match high, 2 remap low, 3 remap high, 4 mask low, 5 mask high, 6 action, and 7 default action, which ignores `wr_win`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_en | input | 1 | Default mapping for misses |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 3 | Window index for a write |
| wr_sel | input | 3 | Field select for a write |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Request present |
| req_bypass | input | 1 | Skip the window lookup |
| req_addr | input | 64 | Outbound address |
| req_action | input | 32 | Action word used on bypass |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | 64 | Translated address |
| rsp_kind | output | 4 | Transaction kind |
| rsp_attr_on | output | 1 | Attributes enabled |
| rsp_tc | output | 3 | Traffic class |
| rsp_flags | output | 4 | Relaxed, no-snoop, poison, ID ordering |
| rsp_hit | output | 1 | A window hit |
| rsp_win | output | 3 | Index of the winning window |
| rsp_default | output | 1 | Default action applied |
| rsp_err | output | 1 | Decode error |

## Verification
The hardest situation to reach from the ports is an address that falls inside several enabled windows at once, with remap values that carry bits outside their masks. Random window placement rarely nests windows. The stimulus therefore programs a large window and a small window inside it on purpose, then disables the low-numbered one and checks that the lookup falls back to the other. A further directed step writes all ones to a mask low word so that the forced-zero granularity bits show on the translated address. Random rounds then place eight windows of random power-of-two sizes and aim half of the lookups inside a chosen window, with map_en and bypass toggled at random.

// File: rtl/obw_pkg.sv
package obw_pkg;

    localparam int ADDR_W    = 64;
    localparam int WORD_W    = 32;
    localparam int GRAN_BITS = 16;

    typedef enum logic [2:0] {
        FLD_MATCH_LO = 3'd0,
        FLD_MATCH_HI = 3'd1,
        FLD_REMAP_LO = 3'd2,
        FLD_REMAP_HI = 3'd3,
        FLD_MASK_LO  = 3'd4,
        FLD_MASK_HI  = 3'd5,
        FLD_ACTION   = 3'd6,
        FLD_DFLT_ACT = 3'd7
    } obw_field_e;

    typedef struct packed {
        logic [3:0] kind;
        logic       attr_on;
        logic [2:0] tc;
        logic [3:0] flags;
    } obw_attr_t;

    // Attribute fields are only honoured when the enable bit is set.
    function automatic obw_attr_t decode_action(input logic [WORD_W-1:0] w);
        obw_attr_t a;
        a.kind    = w[3:0];
        a.attr_on = w[11];
        a.tc      = w[11] ? w[10:8] : 3'd0;
        a.flags   = w[11] ? w[7:4]  : 4'd0;
        return a;
    endfunction

endpackage

// File: rtl/obw_regs.sv
module obw_regs
    import obw_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int WIN_W  = $clog2(NUM_WIN)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [WIN_W-1:0]                 wr_win,
    input  logic [2:0]                       wr_sel,
    input  logic [WORD_W-1:0]                wr_data,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   match_o,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   remap_o,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   mask_o,
    output logic [NUM_WIN-1:0][WORD_W-1:0]   act_o,
    output logic [WORD_W-1:0]                dflt_o
);

    localparam logic [WORD_W-1:0] LO_KEEP = ~((WORD_W'(1) << GRAN_BITS) - WORD_W'(1));

    obw_field_e sel;
    assign sel = obw_field_e'(wr_sel);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        logic hit_w;
        assign hit_w = wr_en && (wr_win == WIN_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                match_o[i] <= '0;
                remap_o[i] <= '0;
                mask_o[i]  <= '0;
                act_o[i]   <= '0;
            end else if (hit_w) begin
                case (sel)
                    FLD_MATCH_LO: match_o[i][31:0]  <= wr_data;
                    FLD_MATCH_HI: match_o[i][63:32] <= wr_data;
                    FLD_REMAP_LO: remap_o[i][31:0]  <= wr_data;
                    FLD_REMAP_HI: remap_o[i][63:32] <= wr_data;
                    FLD_MASK_LO:  mask_o[i][31:0]   <= wr_data & LO_KEEP;
                    FLD_MASK_HI:  mask_o[i][63:32]  <= wr_data;
                    FLD_ACTION:   act_o[i]          <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            dflt_o <= '0;
        else if (wr_en && sel == FLD_DFLT_ACT)
            dflt_o <= wr_data;
    end

    // R11
    act_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd6) |=> act_o[$past(wr_win)] == $past(wr_data));

    // R11
    dflt_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd7) |=> dflt_o == $past(wr_data));

endmodule

// File: rtl/obw_match.sv
module obw_match
    import obw_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]   match_i,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]   mask_i,
    output logic [NUM_WIN-1:0]               hits
);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        assign hits[i] = match_i[i][0] &&
                         ((addr & mask_i[i]) == (match_i[i] & mask_i[i]));
    end

endmodule

// File: rtl/obw_prio.sv
module obw_prio #(
    parameter int NUM_WIN = 8,
    localparam int WIN_W  = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_WIN-1:0] hits,
    output logic [NUM_WIN-1:0] grant,
    output logic [WIN_W-1:0]   idx,
    output logic               any
);

    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                idx = WIN_W'(i);
            end
        end
    end

    assign any = |hits;

    // R5
    grant_oh_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~hits) == '0) && ((|grant) == any));

    // R5
    grant_low_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> ((hits & ((NUM_WIN'(1) << idx) - NUM_WIN'(1))) == '0));

endmodule

// File: rtl/obw_xlate.sv
module obw_xlate
    import obw_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int WIN_W  = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              map_en,
    input  logic              wr_en,
    input  logic [WIN_W-1:0]  wr_win,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              req_valid,
    input  logic              req_bypass,
    input  logic [63:0]       req_addr,
    input  logic [31:0]       req_action,
    output logic              rsp_valid,
    output logic [63:0]       rsp_addr,
    output logic [3:0]        rsp_kind,
    output logic              rsp_attr_on,
    output logic [2:0]        rsp_tc,
    output logic [3:0]        rsp_flags,
    output logic              rsp_hit,
    output logic [WIN_W-1:0]  rsp_win,
    output logic              rsp_default,
    output logic              rsp_err
);

    logic [NUM_WIN-1:0][ADDR_W-1:0] match_q, remap_q, mask_q;
    logic [NUM_WIN-1:0][WORD_W-1:0] act_q;
    logic [WORD_W-1:0]              dflt_q;
    logic [NUM_WIN-1:0]             hits, grant;
    logic [WIN_W-1:0]               win_idx;
    logic                           any_hit;

    obw_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk, .rst, .wr_en, .wr_win, .wr_sel, .wr_data,
        .match_o(match_q), .remap_o(remap_q), .mask_o(mask_q),
        .act_o(act_q), .dflt_o(dflt_q)
    );

    obw_match #(.NUM_WIN(NUM_WIN)) u_match (
        .addr(req_addr), .match_i(match_q), .mask_i(mask_q), .hits(hits)
    );

    obw_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .clk, .rst, .hits(hits), .grant(grant), .idx(win_idx), .any(any_hit)
    );

    logic [ADDR_W-1:0] addr_n;
    obw_attr_t         attr_n;
    logic              hit_n, dflt_n, err_n;

    always_comb begin
        addr_n = req_addr;
        attr_n = '0;
        hit_n  = 1'b0;
        dflt_n = 1'b0;
        err_n  = 1'b0;
        if (req_bypass) begin
            attr_n = decode_action(req_action);
        end else if (any_hit) begin
            addr_n = (remap_q[win_idx] & mask_q[win_idx]) | (req_addr & ~mask_q[win_idx]);
            attr_n = decode_action(act_q[win_idx]);
            hit_n  = 1'b1;
        end else if (map_en) begin
            attr_n = decode_action(dflt_q);
            dflt_n = 1'b1;
        end else begin
            err_n  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_addr    <= '0;
            rsp_kind    <= '0;
            rsp_attr_on <= 1'b0;
            rsp_tc      <= '0;
            rsp_flags   <= '0;
            rsp_hit     <= 1'b0;
            rsp_win     <= '0;
            rsp_default <= 1'b0;
            rsp_err     <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_hit     <= req_valid & hit_n;
            rsp_default <= req_valid & dflt_n;
            rsp_err     <= req_valid & err_n;
            if (req_valid) begin
                rsp_addr    <= addr_n;
                rsp_kind    <= attr_n.kind;
                rsp_attr_on <= attr_n.attr_on;
                rsp_tc      <= attr_n.tc;
                rsp_flags   <= attr_n.flags;
                rsp_win     <= win_idx;
            end
        end
    end

    // R10
    lat_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !rsp_hit && !rsp_err && !rsp_default);

    // R4
    gran_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_addr[15:0] == $past(req_addr[15:0]));

    // R9
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_bypass) |=>
            rsp_addr == $past(req_addr) && !rsp_hit && !rsp_err && !rsp_default);

    // R8
    miss_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_bypass && !map_en && hits == '0) |=> rsp_err && !rsp_hit);

    // R6
    attr_off_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_attr_on) |-> rsp_tc == 3'd0 && rsp_flags == 4'd0);

endmodule

// File: tb/sim_obw_xlate.sv
module sim_obw_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        map_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_win = '0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_bypass = 1'b0;
    logic [63:0] req_addr = '0;
    logic [31:0] req_action = '0;
    logic        rsp_valid;
    logic [63:0] rsp_addr;
    logic [3:0]  rsp_kind;
    logic        rsp_attr_on;
    logic [2:0]  rsp_tc;
    logic [3:0]  rsp_flags;
    logic        rsp_hit;
    logic [2:0]  rsp_win;
    logic        rsp_default;
    logic        rsp_err;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    obw_xlate u0 (
        .clk, .rst, .map_en, .wr_en, .wr_win, .wr_sel, .wr_data,
        .req_valid, .req_bypass, .req_addr, .req_action,
        .rsp_valid, .rsp_addr, .rsp_kind, .rsp_attr_on, .rsp_tc, .rsp_flags,
        .rsp_hit, .rsp_win, .rsp_default, .rsp_err
    );

    // Bench copy of what was written, following R4 and R11.
    logic [63:0] m_match [8];
    logic [63:0] m_remap [8];
    logic [63:0] m_mask  [8];
    logic [31:0] m_act   [8];
    logic [31:0] m_dflt;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int win, input int sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_win = 3'(win); wr_sel = 3'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            0: m_match[win][31:0]  = d;
            1: m_match[win][63:32] = d;
            2: m_remap[win][31:0]  = d;
            3: m_remap[win][63:32] = d;
            4: m_mask[win][31:0]   = d & 32'hFFFF_0000;
            5: m_mask[win][63:32]  = d;
            6: m_act[win]          = d;
            default: m_dflt        = d;
        endcase
    endtask

    task automatic wr_win64(input int win, input logic [63:0] mt, input logic [63:0] rm,
                            input logic [63:0] mk, input logic [31:0] ac);
        wr(win, 0, mt[31:0]); wr(win, 1, mt[63:32]);
        wr(win, 2, rm[31:0]); wr(win, 3, rm[63:32]);
        wr(win, 4, mk[31:0]); wr(win, 5, mk[63:32]);
        wr(win, 6, ac);
    endtask

    function automatic logic [127:0] pack_rsp(input logic [63:0] a, input logic [3:0] k,
        input logic on, input logic [2:0] tc, input logic [3:0] fl, input logic h,
        input logic [2:0] w, input logic d, input logic e);
        return {a, 24'd0, k, 3'd0, on, 1'b0, tc, fl, 5'd0, h, 1'b0, w, 2'd0, d, e, 8'd0};
    endfunction

    function automatic logic [127:0] model(input logic byp, input logic me,
                                           input logic [63:0] a, input logic [31:0] ra);
        logic [31:0] w;
        logic [63:0] o;
        int win;
        win = -1;
        for (int i = 7; i >= 0; i--)
            if (m_match[i][0] && ((a & m_mask[i]) == (m_match[i] & m_mask[i]))) win = i;
        o = a;
        if (byp) w = ra;
        else if (win >= 0) begin
            w = m_act[win];
            o = (m_remap[win] & m_mask[win]) | (a & ~m_mask[win]);
        end else if (me) w = m_dflt;
        else w = 32'd0;
        return pack_rsp(o, w[3:0], w[11], w[11] ? w[10:8] : 3'd0, w[11] ? w[7:4] : 4'd0,
                        !byp && win >= 0, (!byp && win >= 0) ? 3'(win) : 3'd0,
                        !byp && win < 0 && me, !byp && win < 0 && !me);
    endfunction

    function automatic logic [127:0] dut_rsp();
        return pack_rsp(rsp_addr, rsp_kind, rsp_attr_on, rsp_tc, rsp_flags, rsp_hit,
                        rsp_hit ? rsp_win : 3'd0, rsp_default, rsp_err);
    endfunction

    task automatic lookup(input string req, input logic byp, input logic me,
                          input logic [63:0] a, input logic [31:0] ra);
        logic [127:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_bypass = byp; map_en = me; req_addr = a; req_action = ra;
        exp = model(byp, me, a, ra);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " R10 valid"}, {127'd0, rsp_valid}, {127'd0, 1'b1});
        check(req, dut_rsp(), exp);
    endtask

    initial begin
        int wd;
        wd = 0;
        while (wd < 200000) begin
            @(posedge clk);
            wd++;
        end
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240601));
        for (int i = 0; i < 8; i++) begin
            m_match[i] = '0; m_remap[i] = '0; m_mask[i] = '0; m_act[i] = '0;
        end
        m_dflt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of the outputs
        check("R1 reset outputs", {125'd0, rsp_valid, rsp_hit, rsp_err}, 128'd0);
        // R1 R7: windows off, default word is memory kind
        lookup("R1 R7 default after reset", 1'b0, 1'b1, 64'h0000_00AB_CDEF_1234, 32'hFFFF_FFFF);
        check("R7 default flag", {127'd0, rsp_default}, {127'd0, 1'b1});
        // R8: decode error with default mapping off
        lookup("R8 miss error", 1'b0, 1'b0, 64'h0000_00AB_CDEF_1234, 32'h0);
        check("R8 err flag", {127'd0, rsp_err}, {127'd0, 1'b1});
        @(negedge clk);
        check("R10 idle after request", {127'd0, rsp_valid}, 128'd0);

        // R2 R3 R6: 16 MiB window with stray remap bits outside the mask
        wr_win64(2, 64'h0000_0012_3400_0001, 64'h0000_0000_A0FF_0001,
                 64'hFFFF_FFFF_FF00_0000, 32'h0000_0B84);
        lookup("R2 R3 R6 window hit", 1'b0, 1'b0, 64'h0000_0012_3456_789A, 32'h0);
        check("R3 translated address", {64'd0, rsp_addr}, {64'd0, 64'h0000_0000_A056_789A});
        check("R6 kind and attrs", {116'd0, rsp_kind, rsp_attr_on, rsp_tc, rsp_flags},
              {116'd0, 4'h4, 1'b1, 3'd3, 4'b1000});

        // R5: larger window at lower index covers the same address
        wr_win64(1, 64'h0000_0010_0000_0001, 64'h0000_0040_0000_0000,
                 64'hFFFF_FFF0_0000_0000, 32'h0000_00F9);
        lookup("R5 lowest index wins", 1'b0, 1'b0, 64'h0000_0012_3456_789A, 32'h0);
        check("R5 winning index", {125'd0, rsp_win}, {125'd0, 3'd1});
        check("R6 attrs off without enable", {120'd0, rsp_tc, rsp_flags}, 128'd0);

        // R2: disabling window 1 falls back to window 2
        wr(1, 0, 32'h0000_0000);
        lookup("R2 disabled window ignored", 1'b0, 1'b0, 64'h0000_0012_3456_789A, 32'h0);

        // R4: all-ones mask low word leaves a 64 KiB window
        wr_win64(3, 64'h0000_0077_0000_0001, 64'h0000_0001_2345_6789,
                 64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0008);
        lookup("R4 granularity", 1'b0, 1'b0, 64'h0000_0077_0000_BEEF, 32'h0);
        check("R4 low bits pass", {112'd0, rsp_addr[15:0]}, {112'd0, 16'hBEEF});

        // R9: bypass skips a hitting window
        lookup("R9 bypass", 1'b1, 1'b0, 64'h0000_0012_3456_789A, 32'h0000_0DD0);

        // R7 R11: programmed default action word
        wr(5, 7, 32'h0000_08AC);
        lookup("R7 R11 default action", 1'b0, 1'b1, 64'h0000_0F00_0000_1000, 32'h0);

        // Random rounds
        for (int r = 0; r < 4; r++) begin
            for (int w = 0; w < 8; w++) begin
                int sz;
                logic [63:0] mk, mt, rm;
                sz = 16 + int'($urandom % 24);
                mk = ~((64'd1 << sz) - 64'd1);
                mt = {$urandom, $urandom} & mk;
                mt[0] = ($urandom % 4) != 0;
                rm = {$urandom, $urandom};
                if ($urandom % 3 == 0) mk[15:0] = 16'hFFFF;
                wr_win64(w, mt, rm, mk, $urandom);
            end
            wr(0, 7, $urandom);
            for (int n = 0; n < 120; n++) begin
                logic [63:0] a;
                int w;
                w = int'($urandom % 8);
                a = {$urandom, $urandom};
                if ($urandom % 2 == 0) a = (m_match[w] & m_mask[w]) | (a & ~m_mask[w]);
                lookup("R2 R3 R5 R6 R7 R8 R9 random", ($urandom % 10) == 0,
                       $urandom % 2 == 1, a, $urandom);
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule